// File: doc/BRIEF.md
# Timer Output Compare Pin Unit

This block is the output-compare stage of an 8-bit timer/counter. It keeps one internal compare-output state bit and drives one port pin that it shares with ordinary port logic. Each clock it sees the running counter value, the compare register, a 2-bit compare-output action field, the waveform mode, a force strobe, the counting direction of the phase-correct counter, and the port's data and direction bits. The counter itself and the register write path are outside the block and appear here as plain inputs.

On a compare match, and in the pulse-width modes also at counter bottom or on the down-count match, the state bit is updated as the action field says. A nonzero action field gives the pin's value to the timer. The direction bit still decides whether the pin is driven at all. Because the action field is applied at the time of each match, a new field value first takes effect at the next match after it is written. The pin value and enable are registered together with the state bit, so they add one clock of latency and no more.

Top module: `ocu_pin_unit`

## Requirements
- R1: While reset is held and after it is released, the state bit, the pin value and the pin enable are all 0, and they stay 0 until the inputs call for a change.
- R2: When the action field is 00, the state bit keeps its value on every clock, whatever the waveform mode, the match or the force strobe.
- R3: In normal mode (waveform code 00) and in clear-on-match mode (code 01), a match (counter equal to compare) with action 01 toggles the state, with 10 clears it, and with 11 sets it.
- R4: In fast pulse-width mode (code 10), action 10 clears the state on a match and sets it when the counter is 0, and action 11 does the inverse. A match takes priority when both occur together, and action 01 does nothing.
- R5: In phase-correct mode (code 11), action 10 clears the state on a match while counting up (down input 0) and sets it on a match while counting down. Action 11 does the inverse, and action 01 does nothing.
- R6: In waveform codes 00 and 01, a force strobe applies the action at once, even with no match.
- R7: In waveform codes 10 and 11 the force strobe has no effect on the state.
- R8: When the direction bit is 1, the registered pin value follows the new state bit if the action field is nonzero, and follows the port data bit if it is 00. This holds in every waveform mode.
- R9: The pin enable is the direction bit, registered. While the pin enable is 0, the pin value is 0.
- R10: The state bit, the pin value and the pin enable all change on the first clock edge after the inputs that cause the change.
- R11: With the direction bit 0, the state can be preset by a forced action without being driven onto the pin. Setting the direction bit then drives that preset level on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | 8 | Current counter value |
| cmp_val | input | 8 | Compare register value |
| act_sel | input | 2 | Compare-output action field (00 none, 01 toggle, 10 clear, 11 set) |
| wave_sel | input | 2 | Waveform mode (00 normal, 01 clear on match, 10 fast PWM, 11 phase-correct PWM) |
| cnt_down | input | 1 | Counter is counting down (phase-correct mode) |
| force_stb | input | 1 | Force-compare strobe |
| port_data | input | 1 | Port data register bit for the pin |
| port_dir | input | 1 | Port direction bit (1 = output) |
| oc_state | output | 1 | Internal compare-output state |
| pin_val | output | 1 | Registered value driven onto the pin |
| pin_oe | output | 1 | Registered pin drive enable |

## Verification
The hardest case to reach is a state that is loaded while the pin is undriven and only becomes visible when the direction bit turns on. It needs a forced action with the direction bit at 0, then a direction change with no match in between. The bench reaches it with a directed sequence after the sweep. The sweep itself covers every waveform mode, action field, force value, count direction, direction bit and data bit. It places the counter at the compare value, at bottom, and elsewhere, against compare values of 0 and 5. The compare value 0 makes match and bottom occur together, which exercises the priority rule.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    WG_NORMAL = 2'b00,
    WG_CTC    = 2'b01,
    WG_FAST   = 2'b10,
    WG_PHASE  = 2'b11
  } wave_e;

  typedef enum logic [1:0] {
    CO_NONE   = 2'b00,
    CO_TOGGLE = 2'b01,
    CO_CLEAR  = 2'b10,
    CO_SET    = 2'b11
  } act_e;
endpackage

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit,
  output logic             at_bottom
);
  localparam logic [CNT_W-1:0] BOTTOM = '0;

  always_comb begin
    hit       = (cnt_val == cmp_val);
    at_bottom = (cnt_val == BOTTOM);
  end
endmodule

// File: rtl/ocu_action.sv
module ocu_action
  import ocu_pkg::*;
(
  input  wave_e wave,
  input  act_e  act,
  input  logic  hit,
  input  logic  at_bottom,
  input  logic  cnt_down,
  input  logic  force_stb,
  input  logic  cur,
  output logic  nxt
);
  logic non_pwm;
  logic fire;

  always_comb begin
    non_pwm = (wave == WG_NORMAL) || (wave == WG_CTC);
    fire    = hit || (non_pwm && force_stb);
    nxt     = cur;
    unique case (wave)
      WG_NORMAL, WG_CTC: begin
        if (fire) begin
          unique case (act)
            CO_TOGGLE: nxt = ~cur;
            CO_CLEAR:  nxt = 1'b0;
            CO_SET:    nxt = 1'b1;
            default:   nxt = cur;
          endcase
        end
      end
      WG_FAST: begin
        if (act == CO_CLEAR) begin
          if (hit)            nxt = 1'b0;
          else if (at_bottom) nxt = 1'b1;
        end else if (act == CO_SET) begin
          if (hit)            nxt = 1'b1;
          else if (at_bottom) nxt = 1'b0;
        end
      end
      WG_PHASE: begin
        if (hit) begin
          if (act == CO_CLEAR)    nxt = cnt_down;
          else if (act == CO_SET) nxt = ~cnt_down;
        end
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ocu_pin_mux.sv
module ocu_pin_mux
  import ocu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic oc_nxt,
  input  logic port_data,
  input  logic port_dir,
  output logic pin_val,
  output logic pin_oe
);
  logic val_d;
  logic oe_d;

  always_comb begin
    oe_d  = port_dir;
    val_d = 1'b0;
    if (port_dir) begin
      val_d = (act != CO_NONE) ? oc_nxt : port_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_val <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_val <= val_d;
      pin_oe  <= oe_d;
    end
  end

  assert_dir_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_oe == $past(port_dir)));
  assert_port_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_dir && act == CO_NONE) |=> (pin_val == $past(port_data)));
  assert_undriven_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_dir |=> !pin_val);
endmodule

// File: rtl/ocu_pin_unit.sv
module ocu_pin_unit
  import ocu_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       act_sel,
  input  logic [1:0]       wave_sel,
  input  logic             cnt_down,
  input  logic             force_stb,
  input  logic             port_data,
  input  logic             port_dir,
  output logic             oc_state,
  output logic             pin_val,
  output logic             pin_oe
);
  localparam int SYNC_MSB = SYNC_N - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_int_n;
  logic              hit;
  logic              at_bottom;
  logic              oc_nxt;
  logic              oc_q;
  wave_e             wave;
  act_e              act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_MSB];

  assign wave = wave_e'(wave_sel);
  assign act  = act_e'(act_sel);

  ocu_match #(.CNT_W(CNT_W)) u_match (
    .cnt_val   (cnt_val),
    .cmp_val   (cmp_val),
    .hit       (hit),
    .at_bottom (at_bottom)
  );

  ocu_action u_action (
    .wave      (wave),
    .act       (act),
    .hit       (hit),
    .at_bottom (at_bottom),
    .cnt_down  (cnt_down),
    .force_stb (force_stb),
    .cur       (oc_q),
    .nxt       (oc_nxt)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) oc_q <= 1'b0;
    else            oc_q <= oc_nxt;
  end
  assign oc_state = oc_q;

  ocu_pin_mux u_pin (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .act       (act),
    .oc_nxt    (oc_nxt),
    .port_data (port_data),
    .port_dir  (port_dir),
    .pin_val   (pin_val),
    .pin_oe    (pin_oe)
  );

  assert_no_action_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_sel == 2'b00) |=> $stable(oc_q));
  assert_toggle_on_match_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wave_sel[1] && act_sel == 2'b01 && cnt_val == cmp_val) |=> (oc_q != $past(oc_q)));
  assert_fast_idle_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wave_sel == 2'b10 && cnt_val != cmp_val && cnt_val != '0) |=> $stable(oc_q));
  assert_phase_idle_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wave_sel == 2'b11 && cnt_val != cmp_val) |=> $stable(oc_q));
  assert_pin_follows_state_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (port_dir && act_sel != 2'b00) |=> (pin_val == oc_q));
endmodule

// File: tb/test_ocu_pin_unit.sv
module test_ocu_pin_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] cnt_val;
  logic [7:0] cmp_val;
  logic [1:0] act_sel;
  logic [1:0] wave_sel;
  logic       cnt_down;
  logic       force_stb;
  logic       port_data;
  logic       port_dir;
  logic       oc_state;
  logic       pin_val;
  logic       pin_oe;

  int checks = 0;
  int errors = 0;
  logic m_state = 1'b0;

  ocu_pin_unit i_ocu_pin_unit (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_val),
    .act_sel(act_sel), .wave_sel(wave_sel), .cnt_down(cnt_down),
    .force_stb(force_stb), .port_data(port_data), .port_dir(port_dir),
    .oc_state(oc_state), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (wave %0d act %0d cnt %0d cmp %0d frc %b dn %b)",
               tag, got, exp, wave_sel, act_sel, cnt_val, cmp_val, force_stb, cnt_down);
    end
  endtask

  function automatic logic model_next(input logic s);
    logic m, b;
    logic r;
    m = (cnt_val == cmp_val);
    b = (cnt_val == 8'd0);
    r = s;
    if (wave_sel < 2) begin
      if (m || force_stb) begin
        if (act_sel == 1) r = ~s;
        else if (act_sel == 2) r = 1'b0;
        else if (act_sel == 3) r = 1'b1;
      end
    end else if (wave_sel == 2) begin
      if (act_sel == 2) r = m ? 1'b0 : (b ? 1'b1 : s);
      else if (act_sel == 3) r = m ? 1'b1 : (b ? 1'b0 : s);
    end else begin
      if (m && act_sel == 2) r = cnt_down;
      else if (m && act_sel == 3) r = ~cnt_down;
    end
    return r;
  endfunction

  function automatic string state_tag();
    if (act_sel == 0) return "R2";
    if (wave_sel >= 2 && force_stb && cnt_val != cmp_val) return "R7";
    if (wave_sel < 2 && force_stb && cnt_val != cmp_val) return "R6";
    if (wave_sel < 2) return "R3";
    if (wave_sel == 2) return "R4";
    return "R5";
  endfunction

  task automatic step();
    logic nx;
    logic ev, eo;
    string tg;
    nx = model_next(m_state);
    eo = port_dir;
    ev = port_dir ? ((act_sel != 0) ? nx : port_data) : 1'b0;
    tg = state_tag();
    @(posedge clk);
    #1;
    check(oc_state, nx, {tg, " R10 state"});
    check(pin_val, ev, "R8 R10 pin value");
    check(pin_oe, eo, "R9 pin enable");
    m_state = nx;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_val = 8'd1; cmp_val = 8'd5; act_sel = 2'd0; wave_sel = 2'd0;
    cnt_down = 1'b0; force_stb = 1'b0; port_data = 1'b1; port_dir = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(oc_state, 1'b0, "R1 state in reset");
    check(pin_val, 1'b0, "R1 pin in reset");
    check(pin_oe, 1'b0, "R1 enable in reset");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(oc_state, 1'b0, "R1 state after release");
    check(pin_oe, 1'b0, "R1 enable after release");

    for (int cp = 0; cp < 2; cp++) begin
      for (int w = 0; w < 4; w++) begin
        for (int a = 0; a < 4; a++) begin
          for (int f = 0; f < 2; f++) begin
            for (int d = 0; d < 2; d++) begin
              for (int c = 0; c < 3; c++) begin
                for (int pd = 0; pd < 4; pd++) begin
                  cmp_val   = (cp == 0) ? 8'd5 : 8'd0;
                  wave_sel  = w[1:0];
                  act_sel   = a[1:0];
                  force_stb = f[0];
                  cnt_down  = d[0];
                  cnt_val   = (c == 0) ? cmp_val : ((c == 1) ? 8'd0 : 8'd9);
                  port_dir  = pd[1];
                  port_data = pd[0];
                  step();
                end
              end
            end
          end
        end
      end
    end

    // R11: preset while undriven, then enable the pin
    cmp_val = 8'd5; cnt_val = 8'd9; wave_sel = 2'd0; cnt_down = 1'b0;
    port_data = 1'b0; port_dir = 1'b0; act_sel = 2'd2; force_stb = 1'b1;
    step();
    act_sel = 2'd3; step();
    force_stb = 1'b0;
    check(pin_val, 1'b0, "R11 pin undriven while preset");
    port_dir = 1'b1;
    @(posedge clk);
    #1;
    check(pin_val, 1'b1, "R11 preset level on enable");
    check(pin_oe, 1'b1, "R11 enable");
    check(oc_state, 1'b1, "R11 state kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule